// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block holds the pending state of a small group of interrupt sources, each of which can be routed to one or more processor targets. For every source it records the last sampled line level and one pending latch per target. It combines these into an effective pending bit per source and target. Sources are set up one at a time as edge- or level-sensitive, enabled or disabled, and given a target mask. Software can force the latch on or off with strobes. A processor clears its own latch when it acknowledges a source, and signals completion with an end-of-interrupt strobe.

A static mode input picks one of two behaviours. In the latched mode, a level-sensitive source is captured into the latch when its line rises, but only while the source is enabled. The latch is armed again at end-of-interrupt if the line is still high. In the live mode, a level-sensitive source is never latched by hardware. Instead, it shows as pending for as long as its sampled line is high. The software set-pending strobe can still latch it.

A byte-wide readback returns the effective pending bits of eight consecutive sources for one chosen target. Prioritisation, bus decoding and routing are left to the surrounding logic.

Top module: `irq_pend_tracker`

## Requirements
- R1: A rising line on an edge-sensitive source (`edge_cfg`=1) sets the pending latch of every target whose `tgt_mask` bit is 1, whatever the enable bit and mode. Targets whose bit is 0 stay clear. The latch is visible one clock after the rising line is sampled.
- R2: In the latched mode (`mode_live`=0), a rising line on a level-sensitive source (`edge_cfg`=0) sets the latch for its targets only when `enable` is 1.
- R3: In the live mode (`mode_live`=1), a rising line on a level-sensitive source leaves the latch unchanged. Once the line has fallen, the source is no longer pending.
- R4: Effective pending for source s and target t is bit s*N_TGT+t of `pend_eff`. In the live mode it is the latch ORed with (level-sensitive AND sampled line high), regardless of enable. In the latched mode it is the latch alone.
- R5: A `set_pend` bit sets the latch of that source for every target in its mask. In the live mode, a level-sensitive source set this way stays pending with its line low.
- R6: In the latched mode, an end-of-interrupt from target c for a level-sensitive source sets that source's latch for c again. This happens only if the source is enabled, its sampled line is high, and bit c of its mask is 1. In the live mode, end-of-interrupt never sets a latch.
- R7: `rd_byte` bit i equals the effective pending bit of source `rd_sel`*8+i for target `rd_cpu`.
- R8: A falling line clears the sampled level but not the pending latch.
- R9: A `clr_pend` bit clears that source's latch for all targets. In the live mode, a level-sensitive source whose line is still high stays pending.
- R10: An acknowledge (`ack_valid` with `ack_id`, `ack_cpu`) clears only that target's latch of that source. An active-low reset clears every latch and sampled level.
- R11: When a set (line rise, `set_pend` or re-arm) and a clear (`clr_pend` or acknowledge) hit the same latch in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_live | input | 1 | 0 = latched mode, 1 = live mode (static) |
| irq_line | input | N_SRC | Raw interrupt lines |
| edge_cfg | input | N_SRC | 1 = edge-sensitive, 0 = level-sensitive |
| enable | input | N_SRC | Per-source enable |
| tgt_mask | input | N_SRC*N_TGT | Target mask, bit s*N_TGT+t for source s, target t |
| set_pend | input | N_SRC | Software set-pending strobes |
| clr_pend | input | N_SRC | Software clear-pending strobes |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Acknowledged source |
| ack_cpu | input | TW | Acknowledging target |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | IDW | Completed source |
| eoi_cpu | input | TW | Completing target |
| rd_sel | input | BSW | Byte select for readback |
| rd_cpu | input | TW | Target for readback |
| pend_eff | output | N_SRC*N_TGT | Effective pending, bit s*N_TGT+t |
| rd_byte | output | 8 | Readback of eight sources |

## Verification
A software clear-pending strobe and a hardware set of the same latch can land in one clock. The same holds for an acknowledge and a re-arm. The bench provokes this by raising an edge-sensitive line in the very cycle its `clr_pend` bit is high. The source must then read as pending, because the set has priority. A second collision pairs an acknowledge with a line rise on the same source and target, and is judged the same way.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // effective pending bit from the latch and the sampled level
  function automatic logic eff_pend(input logic latch, input logic live,
                                    input logic is_edge, input logic lvl);
    return latch | (live & ~is_edge & lvl);
  endfunction

  // does a rising line arm the latch for this source
  function automatic logic rise_arms(input logic live, input logic is_edge,
                                     input logic en);
    return is_edge | (~live & en);
  endfunction

  // may end-of-interrupt re-arm the latch
  function automatic logic eoi_rearms(input logic live, input logic is_edge,
                                      input logic en, input logic lvl);
    return ~live & ~is_edge & en & lvl;
  endfunction

endpackage

// File: rtl/ipt_src_cell.sv
module ipt_src_cell #(
  parameter int N_TGT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_live,
  input  logic             line,
  input  logic             is_edge,
  input  logic             en,
  input  logic [N_TGT-1:0] tgt,
  input  logic             set_sw,
  input  logic             clr_sw,
  input  logic [N_TGT-1:0] ack_hit,
  input  logic [N_TGT-1:0] eoi_hit,
  output logic [N_TGT-1:0] pend_eff
);
  logic             lvl_q;
  logic [N_TGT-1:0] latch_q, latch_d, set_vec, clr_vec;
  logic             rise_ev, hw_set_ev, eoi_ok;

  assign rise_ev   = line & ~lvl_q;
  assign hw_set_ev = rise_ev & ipt_pkg::rise_arms(mode_live, is_edge, en);
  assign eoi_ok    = ipt_pkg::eoi_rearms(mode_live, is_edge, en, lvl_q);

  assign set_vec = ({N_TGT{hw_set_ev | set_sw}} & tgt) |
                   ({N_TGT{eoi_ok}} & eoi_hit & tgt);
  assign clr_vec = {N_TGT{clr_sw}} | ack_hit;
  // set has priority over clear
  assign latch_d = set_vec | (latch_q & ~clr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      lvl_q   <= line;
      latch_q <= latch_d;
    end
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_eff
    assign pend_eff[t] = ipt_pkg::eff_pend(latch_q[t], mode_live, is_edge, lvl_q);
  end

  // R1: edge rise latches all masked targets
  a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && rise_ev) |=> ((latch_q & $past(tgt)) == $past(tgt)));

  // R2: disabled level source in latched mode gains no latch bit
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_live && !is_edge && !en && rise_ev && !set_sw)
      |=> ((latch_q & ~$past(latch_q)) == '0));

  // R3: live mode level rise does not latch
  a_r3_live_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_live && !is_edge && rise_ev && !set_sw)
      |=> ((latch_q & ~$past(latch_q)) == '0));

  // R4: live mode shows a high level line as pending
  a_r4_live_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_live && !is_edge && line) |=> (!mode_live || is_edge || (&pend_eff)));

  // R8: without a clear, no latch bit drops
  a_r8_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_sw && ack_hit == '0) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

endmodule

// File: rtl/ipt_byte_mux.sv
module ipt_byte_mux #(
  parameter int N_SRC = 16,
  parameter int N_TGT = 2,
  parameter int BSW   = 1,
  parameter int TW    = 1
) (
  input  logic [N_SRC*N_TGT-1:0] pend,
  input  logic [BSW-1:0]         sel,
  input  logic [TW-1:0]          cpu,
  output logic [7:0]             byte_o
);
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < 8; i++) begin
      int src;
      src = int'(sel) * 8 + i;
      if (src < N_SRC && int'(cpu) < N_TGT)
        byte_o[i] = pend[src * N_TGT + int'(cpu)];
    end
  end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
  parameter int N_SRC = 16,
  parameter int N_TGT = 2,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int TW  = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int BSW = (N_SRC > 8) ? $clog2((N_SRC + 7) / 8) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_live,
  input  logic [N_SRC-1:0]       irq_line,
  input  logic [N_SRC-1:0]       edge_cfg,
  input  logic [N_SRC-1:0]       enable,
  input  logic [N_SRC*N_TGT-1:0] tgt_mask,
  input  logic [N_SRC-1:0]       set_pend,
  input  logic [N_SRC-1:0]       clr_pend,
  input  logic                   ack_valid,
  input  logic [IDW-1:0]         ack_id,
  input  logic [TW-1:0]          ack_cpu,
  input  logic                   eoi_valid,
  input  logic [IDW-1:0]         eoi_id,
  input  logic [TW-1:0]          eoi_cpu,
  input  logic [BSW-1:0]         rd_sel,
  input  logic [TW-1:0]          rd_cpu,
  output logic [N_SRC*N_TGT-1:0] pend_eff,
  output logic [7:0]             rd_byte
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [N_TGT-1:0] ack_hit, eoi_hit;
    for (genvar t = 0; t < N_TGT; t++) begin : g_dec
      assign ack_hit[t] = ack_valid && (ack_id == IDW'(s)) && (ack_cpu == TW'(t));
      assign eoi_hit[t] = eoi_valid && (eoi_id == IDW'(s)) && (eoi_cpu == TW'(t));
    end
    ipt_src_cell #(.N_TGT(N_TGT)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_live(mode_live),
      .line     (irq_line[s]),
      .is_edge  (edge_cfg[s]),
      .en       (enable[s]),
      .tgt      (tgt_mask[s*N_TGT +: N_TGT]),
      .set_sw   (set_pend[s]),
      .clr_sw   (clr_pend[s]),
      .ack_hit  (ack_hit),
      .eoi_hit  (eoi_hit),
      .pend_eff (pend_eff[s*N_TGT +: N_TGT])
    );
  end

  ipt_byte_mux #(.N_SRC(N_SRC), .N_TGT(N_TGT), .BSW(BSW), .TW(TW)) u_rd (
    .pend  (pend_eff),
    .sel   (rd_sel),
    .cpu   (rd_cpu),
    .byte_o(rd_byte)
  );
endmodule

// File: tb/irq_pend_tracker_tb_top.sv
module irq_pend_tracker_tb_top;
  localparam int NS = 16;
  localparam int NT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_live = 1'b0;
  logic [NS-1:0] irq_line = '0, edge_cfg = '0, enable = '0, set_pend = '0, clr_pend = '0;
  logic [NS*NT-1:0] tgt_mask = '1;
  logic ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [3:0] ack_id = '0, eoi_id = '0;
  logic ack_cpu = 1'b0, eoi_cpu = 1'b0, rd_sel = 1'b0, rd_cpu = 1'b0;
  logic [NS*NT-1:0] pend_eff;
  logic [7:0] rd_byte;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_pend_tracker #(.N_SRC(NS), .N_TGT(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_live(mode_live), .irq_line(irq_line),
    .edge_cfg(edge_cfg), .enable(enable), .tgt_mask(tgt_mask),
    .set_pend(set_pend), .clr_pend(clr_pend), .ack_valid(ack_valid),
    .ack_id(ack_id), .ack_cpu(ack_cpu), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .eoi_cpu(eoi_cpu), .rd_sel(rd_sel), .rd_cpu(rd_cpu),
    .pend_eff(pend_eff), .rd_byte(rd_byte)
  );

  // {mode_live, edge, enable, pending after rise, pending after fall}
  localparam logic [4:0] VEC [8] = '{
    5'b01111, 5'b01011, 5'b00111, 5'b00000,
    5'b11111, 5'b11011, 5'b10110, 5'b10010
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic live);
    rst_n = 1'b0;
    mode_live = live;
    irq_line = '0; edge_cfg = '0; enable = '0; set_pend = '0; clr_pend = '0;
    tgt_mask = '1; ack_valid = 1'b0; eoi_valid = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(20ns * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R10: reset state
    chk(pend_eff, '0, "R10 reset pend");
    chk(rd_byte, 8'h00, "R7 reset byte");

    // table walk: R1 R2 R3 R4 R8
    for (int k = 0; k < 8; k++) begin
      int s;
      s = k * 2;
      do_reset(VEC[k][4]);
      edge_cfg[s] = VEC[k][3];
      enable[s] = VEC[k][2];
      irq_line[s] = 1'b1;
      step();
      chk(pend_eff[s*NT +: NT], {NT{VEC[k][1]}}, "R1/R2/R4 after rise");
      irq_line[s] = 1'b0;
      step();
      chk(pend_eff[s*NT +: NT], {NT{VEC[k][0]}}, "R3/R8 after fall");
    end

    // R1: mask restricts targets
    do_reset(1'b0);
    edge_cfg[3] = 1'b1;
    tgt_mask[3*NT +: NT] = 2'b10;
    irq_line[3] = 1'b1;
    step();
    chk(pend_eff[3*NT +: NT], 2'b10, "R1 mask");

    // R5: software set on live level source
    do_reset(1'b1);
    set_pend[5] = 1'b1;
    step();
    set_pend[5] = 1'b0;
    chk(pend_eff[5*NT +: NT], 2'b11, "R5 sw set");
    // R9: clear drops it
    clr_pend[5] = 1'b1;
    step();
    clr_pend[5] = 1'b0;
    chk(pend_eff[5*NT +: NT], 2'b00, "R9 sw clear");
    // R9: clear cannot hide a live high level
    irq_line[5] = 1'b1;
    step();
    clr_pend[5] = 1'b1;
    step();
    clr_pend[5] = 1'b0;
    chk(pend_eff[5*NT +: NT], 2'b11, "R9 live level kept");

    // R10 and R6: latched mode acknowledge then re-arm
    do_reset(1'b0);
    enable[6] = 1'b1;
    irq_line[6] = 1'b1;
    step();
    ack_valid = 1'b1; ack_id = 4'd6; ack_cpu = 1'b0;
    step();
    ack_valid = 1'b0;
    chk(pend_eff[6*NT +: NT], 2'b10, "R10 ack one target");
    eoi_valid = 1'b1; eoi_id = 4'd6; eoi_cpu = 1'b0;
    step();
    eoi_valid = 1'b0;
    chk(pend_eff[6*NT +: NT], 2'b11, "R6 eoi rearm");

    // R6: target outside mask not re-armed
    do_reset(1'b0);
    enable[7] = 1'b1;
    tgt_mask[7*NT +: NT] = 2'b10;
    irq_line[7] = 1'b1;
    step();
    eoi_valid = 1'b1; eoi_id = 4'd7; eoi_cpu = 1'b0;
    step();
    eoi_valid = 1'b0;
    chk(pend_eff[7*NT +: NT], 2'b10, "R6 mask blocks rearm");

    // R6: live mode no rearm
    do_reset(1'b1);
    enable[8] = 1'b1;
    irq_line[8] = 1'b1;
    step();
    eoi_valid = 1'b1; eoi_id = 4'd8; eoi_cpu = 1'b0;
    step();
    eoi_valid = 1'b0;
    irq_line[8] = 1'b0;
    step();
    chk(pend_eff[8*NT +: NT], 2'b00, "R6 live no rearm");

    // R7: readback
    do_reset(1'b0);
    edge_cfg[9] = 1'b1; edge_cfg[11] = 1'b1;
    irq_line[9] = 1'b1; irq_line[11] = 1'b1;
    step();
    rd_sel = 1'b1; rd_cpu = 1'b0;
    #1;
    chk(rd_byte, 8'h0A, "R7 upper byte");
    rd_sel = 1'b0;
    #1;
    chk(rd_byte, 8'h00, "R7 lower byte");

    // R11: clear and edge rise in the same cycle
    do_reset(1'b0);
    edge_cfg[2] = 1'b1;
    irq_line[2] = 1'b1;
    clr_pend[2] = 1'b1;
    step();
    clr_pend[2] = 1'b0;
    chk(pend_eff[2*NT +: NT], 2'b11, "R11 set beats clear");
    // R11: acknowledge and edge rise together
    irq_line[2] = 1'b0;
    step();
    irq_line[2] = 1'b1;
    ack_valid = 1'b1; ack_id = 4'd2; ack_cpu = 1'b1;
    step();
    ack_valid = 1'b0;
    chk(pend_eff[2*NT +: NT], 2'b11, "R11 set beats ack");

    // R10: reset clears latches
    rst_n = 1'b0;
    #1;
    chk(pend_eff, '0, "R10 reset clears");
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule